// File: doc/BRIEF.md
# Dual-Processor Port Mailbox

This block lets two processors exchange bytes through one shared 8-bit port. The master side sits on a synchronous register interface. It writes a byte into an output register, and the slave can pick that byte up from the port. In the other direction the slave drives a byte onto the port and strobes it into a set of capture cells. The master reads those cells directly on its read-data bus.

The slave has no clock. It presents active-low chip-select, read and write lines, and the block decodes these into a read enable and a write strobe. The read enable turns on the port's output driver, modelled here as an output-enable signal. The write strobe clocks the capture cells when it deasserts.

Both slave strobes are brought into the master clock domain through a two-stage synchroniser. The end of each slave access then updates a full flag for its direction:
- The outbound flag is set by a master write and cleared by a completed slave read.
- The inbound flag is set by a completed slave write and cleared by a master read.

Top module: `duplex_mailbox`

## Requirements
- R1: After reset, txFull, rxFull, portOut and mRdData are all 0, and portOe is 0 while the slave lines are idle (all high).
- R2: A cycle with mWrEn high loads mWrData into the output register, so that portOut equals it and txFull is 1 after the next rising clock edge.
- R3: portOe is 1 exactly when sCsN=0, sRdN=0 and sWrN=1, with no clock involved. While it is 1, portOut shows the last byte the master wrote.
- R4: A read attempt with sCsN=1, or with sRdN and sWrN both low, leaves portOe at 0 and does not clear txFull.
- R5: After the slave read enable deasserts, txFull is still 1 at the first rising edge and is 0 from the third rising edge on.
- R6: The capture cells take portIn at the moment the slave write strobe (sCsN=0, sWrN=0, sRdN=1) deasserts. mRdData shows the captured byte at once and keeps it while portIn changes later.
- R7: rxFull is still 0 one rising edge after a slave write ends and is 1 from the third edge on. A cycle with mRdEn high clears it at the next edge.
- R8: When a master write and a completed slave read fall in the same cycle, the write wins and txFull stays 1.
- R9: Without mWrEn, portOut keeps its value from one cycle to the next.
- R10: A write attempt with sCsN=1 changes neither mRdData nor rxFull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mWrEn | input | 1 | Master write strobe for the output register |
| mWrData | input | 8 | Master write data |
| mRdEn | input | 1 | Master read of the capture cells; clears rxFull |
| mRdData | output | 8 | Capture cell contents |
| txFull | output | 1 | Master-to-slave byte waiting |
| rxFull | output | 1 | Slave-to-master byte waiting |
| sCsN | input | 1 | Slave chip select, active low |
| sRdN | input | 1 | Slave read, active low |
| sWrN | input | 1 | Slave write, active low |
| portIn | input | 8 | Byte driven on the port by the slave |
| portOut | output | 8 | Byte the block drives on the port |
| portOe | output | 1 | Port output driver enable |

## Verification
The assertions assume that the slave holds each strobe level for at least two master clock periods. This lets the synchroniser see every access. They also assume that the slave drives portIn stable around the end of a write. The bench changes the slave lines only on falling clock edges and holds every slave access for at least four cycles. It also waits at least five cycles after each access before the next one starts, so the flag checks only ever face one completion at a time.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic loadTx;    // master write of the output register
    logic slvRdAct;  // decoded slave read enable
    logic slvWrAct;  // decoded slave write strobe
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mWrEn,
  input  logic         mRdEn,
  input  logic         sCsN,
  input  logic         sRdN,
  input  logic         sWrN,
  output mboxStrobes_t strobes,
  output logic         txFull,
  output logic         rxFull
);
  logic       slvRdAct, slvWrAct;
  logic [1:0] syncOut;
  logic [1:0] syncDly;
  logic       rdDone, wrDone;

  assign slvRdAct = !sCsN && !sRdN && sWrN;
  assign slvWrAct = !sCsN && !sWrN && sRdN;

  mbox_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({slvWrAct, slvRdAct}),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncDly <= '0;
    else       syncDly <= syncOut;
  end

  assign rdDone = syncDly[0] && !syncOut[0];
  assign wrDone = syncDly[1] && !syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull <= 1'b0;
      rxFull <= 1'b0;
    end else begin
      if (mWrEn)       txFull <= 1'b1;
      else if (rdDone) txFull <= 1'b0;
      if (wrDone)      rxFull <= 1'b1;
      else if (mRdEn)  rxFull <= 1'b0;
    end
  end

  assign strobes.loadTx   = mWrEn;
  assign strobes.slvRdAct = slvRdAct;
  assign strobes.slvWrAct = slvWrAct;
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  mboxStrobes_t     strobes,
  input  logic [WIDTH-1:0] mWrData,
  input  logic [WIDTH-1:0] portIn,
  output logic [WIDTH-1:0] mRdData,
  output logic [WIDTH-1:0] portOut,
  output logic             portOe
);
  logic [WIDTH-1:0] txReg;
  logic [WIDTH-1:0] captureReg;
  logic             capClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txReg <= '0;
    else if (strobes.loadTx) txReg <= mWrData;
  end

  // capture cells in register mode, clocked by the end of the slave write
  assign capClk = strobes.slvWrAct;

  always_ff @(negedge capClk or negedge rstN) begin
    if (!rstN) captureReg <= '0;
    else       captureReg <= portIn;
  end

  assign portOut = txReg;
  assign portOe  = strobes.slvRdAct;
  assign mRdData = captureReg;
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbox_pkg::*;
#(
  parameter int WIDTH       = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mWrEn,
  input  logic [WIDTH-1:0] mWrData,
  input  logic             mRdEn,
  output logic [WIDTH-1:0] mRdData,
  output logic             txFull,
  output logic             rxFull,
  input  logic             sCsN,
  input  logic             sRdN,
  input  logic             sWrN,
  input  logic [WIDTH-1:0] portIn,
  output logic [WIDTH-1:0] portOut,
  output logic             portOe
);
  mboxStrobes_t strobes;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mWrEn  (mWrEn),
    .mRdEn  (mRdEn),
    .sCsN   (sCsN),
    .sRdN   (sRdN),
    .sWrN   (sWrN),
    .strobes(strobes),
    .txFull (txFull),
    .rxFull (rxFull)
  );

  mbox_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .mWrData(mWrData),
    .portIn (portIn),
    .mRdData(mRdData),
    .portOut(portOut),
    .portOe (portOe)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             mWrEn,
  input logic [WIDTH-1:0] mWrData,
  input logic             mRdEn,
  input logic [WIDTH-1:0] mRdData,
  input logic             txFull,
  input logic             rxFull,
  input logic             sCsN,
  input logic             sRdN,
  input logic             sWrN,
  input logic [WIDTH-1:0] portIn,
  input logic [WIDTH-1:0] portOut,
  input logic             portOe
);
  // R2
  tx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    mWrEn |=> (portOut == $past(mWrData)) && txFull);

  // R2
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFull) |-> $past(mWrEn));

  // R8
  tx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFull) |-> !$past(mWrEn));

  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(mRdEn));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mWrEn |=> $stable(portOut));

  // R3
  oe_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    portOe |-> (!sCsN && !sRdN && sWrN));
endmodule

bind duplex_mailbox mbox_checker #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_duplex_mailbox.sv
module test_duplex_mailbox;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mWrEn = 1'b0;
  logic [7:0] mWrData = '0;
  logic       mRdEn = 1'b0;
  logic [7:0] mRdData;
  logic       txFull, rxFull;
  logic       sCsN = 1'b1, sRdN = 1'b1, sWrN = 1'b1;
  logic [7:0] portIn = '0;
  logic [7:0] portOut;
  logic       portOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  duplex_mailbox i_duplex_mailbox (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic masterWrite(logic [7:0] d);
    @(negedge clk);
    mWrEn = 1'b1; mWrData = d;
    @(negedge clk);
    mWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 txFull", txFull, 0);
    check("R1 rxFull", rxFull, 0);
    check("R1 portOut", portOut, 0);
    check("R1 mRdData", mRdData, 0);
    check("R1 portOe", portOe, 0);
  endtask

  task automatic testMasterWrite();
    masterWrite(8'h3C);
    check("R2 portOut", portOut, 8'h3C);
    check("R2 txFull", txFull, 1);
    idle(3);
    check("R9 portOut hold", portOut, 8'h3C);
  endtask

  task automatic testIgnoredReads();
    @(negedge clk);
    sCsN = 1'b1; sRdN = 1'b0;
    #1 check("R4 oe cs high", portOe, 0);
    idle(4);
    sRdN = 1'b1;
    idle(5);
    check("R4 txFull kept cs high", txFull, 1);
    sCsN = 1'b0; sRdN = 1'b0; sWrN = 1'b0;
    #1 check("R4 oe rd+wr", portOe, 0);
    idle(4);
    sRdN = 1'b1; sWrN = 1'b1; sCsN = 1'b1;
    idle(5);
    check("R4 txFull kept rd+wr", txFull, 1);
  endtask

  task automatic testSlaveRead();
    @(negedge clk);
    sCsN = 1'b0; sRdN = 1'b0;
    #1 check("R3 portOe", portOe, 1);
    check("R3 portOut", portOut, 8'h3C);
    idle(4);
    sRdN = 1'b1;
    #1 check("R3 oe off", portOe, 0);
    sCsN = 1'b1;
    idle(1);
    check("R5 txFull early", txFull, 1);
    idle(4);
    check("R5 txFull cleared", txFull, 0);
  endtask

  task automatic testWriteWins();
    masterWrite(8'h11);
    @(negedge clk);
    sCsN = 1'b0; sRdN = 1'b0;
    idle(4);
    sRdN = 1'b1; sCsN = 1'b1;
    mWrEn = 1'b1; mWrData = 8'h22;
    idle(6);
    mWrEn = 1'b0;
    check("R8 txFull", txFull, 1);
    check("R8 portOut", portOut, 8'h22);
  endtask

  task automatic testSlaveWrite();
    @(negedge clk);
    portIn = 8'hA5; sCsN = 1'b0; sWrN = 1'b0;
    idle(4);
    sWrN = 1'b1;
    #1 sCsN = 1'b1; portIn = 8'h5A;
    #1 check("R6 capture", mRdData, 8'hA5);
    idle(1);
    check("R7 rxFull early", rxFull, 0);
    idle(4);
    check("R7 rxFull set", rxFull, 1);
    check("R6 capture hold", mRdData, 8'hA5);
    mRdEn = 1'b1;
    @(negedge clk);
    mRdEn = 1'b0;
    check("R7 rxFull cleared", rxFull, 0);
  endtask

  task automatic testIgnoredWrite();
    @(negedge clk);
    portIn = 8'hF0; sCsN = 1'b1; sWrN = 1'b0;
    idle(4);
    sWrN = 1'b1;
    idle(5);
    check("R10 mRdData", mRdData, 8'hA5);
    check("R10 rxFull", rxFull, 0);
  endtask

  initial begin
    idle(3);
    #1 testReset();
    rstN = 1'b1;
    testMasterWrite();
    testIgnoredReads();
    testSlaveRead();
    testWriteWins();
    testSlaveWrite();
    testIgnoredWrite();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule